// File: doc/BRIEF.md
# Processor-to-Memory Crossbar Switch

This block joins P processor request ports to M memory module ports through a full grid of crosspoints, one at every processor/module intersection. Each processor presents a request stream: a valid flag, an address, write data and a write-enable. The top bits of the address name the target module. Every module column has its own fixed-priority arbiter. The arbiter picks one requesting processor and steers that processor's word address, write data and write-enable onto the module's bus. Because each column decides alone, requests aimed at different modules are all served in the same cycle.

The processor request interface is valid/ready. `req_ready[p]` is the grant, and it may depend on `req_valid[p]` within the same cycle. A processor whose valid is high and whose ready is low has lost arbitration. It must hold valid, address, data and write-enable unchanged until a cycle in which ready is high. A transfer happens in any cycle where valid and ready are both high. The memory side has no back-pressure: a module accepts whatever it sees with `mem_valid` high. For a read, the module presents its read data on `mem_rdata` in the following cycle. The crossbar carries that data back to the processor that issued the read, using the module index it registered at grant time.

Top module: `proc_mem_xbar`

## Requirements
- R1: The target module of a request is address bits [AW-1 : AW-log2(M)] (bits 15:14 by default). The remaining low bits (13:0) are the word address placed on that module's `mem_addr`.
- R2: When several valid requests target the same module, only the lowest-numbered processor among them is granted. A module grants at most one processor in a cycle.
- R3: A valid request that is not granted has `req_ready` low in that cycle. A granted request has `req_ready` high in the same cycle in which its valid is presented.
- R4: Valid requests whose targets are all different are all granted in the same cycle.
- R5: In a cycle where module m grants processor p, `mem_valid[m]` is high and `mem_addr`, `mem_wdata` and `mem_we` of module m equal processor p's word address, write data and write-enable.
- R6: A granted read (we = 0) raises `rsp_valid[p]` exactly one cycle later. In that cycle `rsp_data[p]` carries the read data of the module the read targeted.
- R7: A granted write (we = 1) and a request not granted produce no response: `rsp_valid[p]` is low in the following cycle.
- R8: While reset is asserted (`rst_n` low), every `rsp_valid` bit is low.
- R9: A module targeted by no valid request has `mem_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 4 | Per-processor request valid |
| req_ready | output | 4 | Per-processor grant (ready) |
| req_addr | input | 64 | Per-processor 16-bit address, processor p at bits [16p+15:16p] |
| req_wdata | input | 128 | Per-processor 32-bit write data |
| req_we | input | 4 | Per-processor write-enable (1 = write, 0 = read) |
| mem_valid | output | 4 | Per-module access strobe |
| mem_we | output | 4 | Per-module write-enable |
| mem_addr | output | 56 | Per-module 14-bit word address |
| mem_wdata | output | 128 | Per-module 32-bit write data |
| mem_rdata | input | 128 | Per-module 32-bit read data, valid the cycle after a read |
| rsp_valid | output | 4 | Per-processor read response valid |
| rsp_data | output | 128 | Per-processor 32-bit read response data |

## Verification
The bench builds the block at its defaults: four processors, four modules, a 16-bit address and 32-bit data. This small grid allows a full sweep. Every assignment of targets to the four processors (256), combined with every subset of active processors (16), gives 4096 request patterns. Together these cover every conflict shape: no contention, every pairing, every three-way collision and all four processors on one module. The read/write mix and the word addresses are varied arithmetically per pattern. The memory model returns data derived from the module index and word address, so each response shows whether it came from the right module and the right word.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Isolate the lowest set bit of a request vector (at most 32 requesters).
  function automatic logic [31:0] lowest_set(input logic [31:0] req);
    return req & (~req + 32'd1);
  endfunction

endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
  parameter int AW = 16,
  parameter int M  = 4
) (
  input  logic [AW-1:0]        addr,
  output logic [$clog2(M)-1:0] sel,
  output logic [M-1:0]         hit,
  output logic [AW-$clog2(M)-1:0] word
);
  localparam int MW  = $clog2(M);
  localparam int WAW = AW - MW;

  always_comb begin
    sel  = addr[AW-1 -: MW];
    word = addr[WAW-1:0];
    hit  = '0;
    hit[sel] = 1'b1;
  end
endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter #(
  parameter int P = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [P-1:0]         want,
  output logic [P-1:0]         gnt,
  output logic [$clog2(P)-1:0] idx,
  output logic                 any
);
  localparam int PW = $clog2(P);

  always_comb begin
    gnt = P'(xbar_pkg::lowest_set(32'(want)));
    any = |want;
    idx = '0;
    for (int i = 0; i < P; i++)
      if (gnt[i]) idx = PW'(i);
  end

  // R2: never more than one winner per module
  p_single_winner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R2: processor 0 always wins when it asks
  p_top_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
    want[0] |-> gnt[0]);
  // R3: a grant only goes to a requester
  p_grant_in_want_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~want) == '0);
endmodule

// File: rtl/xbar_return.sv
module xbar_return #(
  parameter int M  = 4,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_fire,
  input  logic [$clog2(M)-1:0] rd_sel,
  input  logic [M*DW-1:0]      mem_rdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_data
);
  localparam int MW = $clog2(M);

  logic          pend_q;
  logic [MW-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      pend_q <= rd_fire;
      if (rd_fire) sel_q <= rd_sel;
    end
  end

  assign rsp_valid = pend_q;
  assign rsp_data  = mem_rdata[sel_q*DW +: DW];

  // R6: a granted read answers on the next cycle
  p_read_answers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);
  // R7: no response without a granted read one cycle earlier
  p_no_stray_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_fire));
endmodule

// File: rtl/proc_mem_xbar.sv
module proc_mem_xbar #(
  parameter int P  = 4,
  parameter int M  = 4,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [P-1:0]               req_valid,
  output logic [P-1:0]               req_ready,
  input  logic [P*AW-1:0]            req_addr,
  input  logic [P*DW-1:0]            req_wdata,
  input  logic [P-1:0]               req_we,
  output logic [M-1:0]               mem_valid,
  output logic [M-1:0]               mem_we,
  output logic [M*(AW-$clog2(M))-1:0] mem_addr,
  output logic [M*DW-1:0]            mem_wdata,
  input  logic [M*DW-1:0]            mem_rdata,
  output logic [P-1:0]               rsp_valid,
  output logic [P*DW-1:0]            rsp_data
);
  localparam int MW  = $clog2(M);
  localparam int PW  = $clog2(P);
  localparam int WAW = AW - MW;

  logic [MW-1:0]  sel  [P];
  logic [M-1:0]   hit  [P];
  logic [WAW-1:0] word [P];
  logic [P-1:0]   want [M];
  logic [P-1:0]   gnt  [M];
  logic [PW-1:0]  idx  [M];

  // Crosspoint row: each processor decodes its own target
  for (genvar p = 0; p < P; p++) begin : g_row
    xbar_decode #(.AW(AW), .M(M)) u_dec (
      .addr (req_addr[p*AW +: AW]),
      .sel  (sel[p]),
      .hit  (hit[p]),
      .word (word[p])
    );
  end

  // Crosspoint column: one arbiter and forward mux per module
  for (genvar m = 0; m < M; m++) begin : g_col
    always_comb
      for (int p = 0; p < P; p++)
        want[m][p] = req_valid[p] & hit[p][m];

    xbar_arbiter #(.P(P)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want[m]),
      .gnt   (gnt[m]),
      .idx   (idx[m]),
      .any   (mem_valid[m])
    );

    assign mem_addr[m*WAW +: WAW] = word[idx[m]];
    assign mem_wdata[m*DW +: DW]  = req_wdata[idx[m]*DW +: DW];
    assign mem_we[m]              = req_we[idx[m]];

    for (genvar p = 0; p < P; p++) begin : g_chk
      // R1: a grant from module m only goes to a request addressed to m
      p_grant_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[m][p] |-> (req_valid[p] && req_addr[p*AW+AW-1 -: MW] == MW'(m)));
      // R5: granted column carries that processor's word address
      p_fwd_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[m][p] |-> (mem_valid[m] && mem_addr[m*WAW +: WAW] == req_addr[p*AW +: WAW]));
    end
  end

  // Processor side: ready gathering and read return path
  always_comb
    for (int p = 0; p < P; p++) begin
      req_ready[p] = 1'b0;
      for (int m = 0; m < M; m++)
        req_ready[p] = req_ready[p] | gnt[m][p];
    end

  for (genvar p = 0; p < P; p++) begin : g_ret
    xbar_return #(.M(M), .DW(DW)) u_ret (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_fire   (req_valid[p] & req_ready[p] & ~req_we[p]),
      .rd_sel    (sel[p]),
      .mem_rdata (mem_rdata),
      .rsp_valid (rsp_valid[p]),
      .rsp_data  (rsp_data[p*DW +: DW])
    );
  end
endmodule

// File: tb/tb_proc_mem_xbar.sv
module tb_proc_mem_xbar;
  localparam int P = 4, M = 4, AW = 16, DW = 32;
  localparam int WAW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [P-1:0] req_valid = '0, req_ready, req_we = '0;
  logic [P*AW-1:0] req_addr = '0;
  logic [P*DW-1:0] req_wdata = '0;
  logic [M-1:0] mem_valid, mem_we;
  logic [M*WAW-1:0] mem_addr;
  logic [M*DW-1:0] mem_wdata, mem_rdata;
  logic [P-1:0] rsp_valid;
  logic [P*DW-1:0] rsp_data;

  proc_mem_xbar #(.P(P), .M(M), .AW(AW), .DW(DW)) dut (.*);

  function automatic logic [DW-1:0] mem_word(input int m, input logic [WAW-1:0] w);
    return {2'(m), 2'b01, w, 14'h1A5};
  endfunction

  // Memory model: registered read, data derived from module and word
  always_ff @(posedge clk)
    for (int m = 0; m < M; m++)
      if (mem_valid[m] && !mem_we[m])
        mem_rdata[m*DW +: DW] <= mem_word(m, mem_addr[m*WAW +: WAW]);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic          exp_rsp  [P];
  logic [DW-1:0] exp_data [P];

  initial begin
    for (int p = 0; p < P; p++) begin exp_rsp[p] = 0; exp_data[p] = '0; end
    repeat (3) @(negedge clk);
    chk("R8 rsp_valid in reset", 64'(rsp_valid), 0);
    chk("R9 mem_valid idle", 64'(mem_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 rsp_valid after reset", 64'(rsp_valid), 0);

    for (int pat = 0; pat < 4096; pat++) begin
      int tgt [P];
      logic [WAW-1:0] wd [P];
      int win [M];
      // responses of the previous pattern
      for (int p = 0; p < P; p++) begin
        chk(exp_rsp[p] ? "R6 rsp_valid" : "R7 rsp_valid", 64'(rsp_valid[p]), 64'(exp_rsp[p]));
        if (exp_rsp[p]) chk("R6 rsp_data", 64'(rsp_data[p*DW +: DW]), 64'(exp_data[p]));
      end
      for (int p = 0; p < P; p++) begin
        tgt[p] = (pat >> (2*p)) & 3;
        wd[p]  = WAW'(pat*7 + p*3);
        req_valid[p] = pat[8+p];
        req_we[p]    = ((pat*5 + p) % 3) == 0;
        req_addr[p*AW +: AW]  = {2'(tgt[p]), wd[p]};
        req_wdata[p*DW +: DW] = {16'(pat), 16'(p)};
      end
      for (int m = 0; m < M; m++) begin
        win[m] = -1;
        for (int p = 0; p < P; p++)
          if (win[m] < 0 && req_valid[p] && tgt[p] == m) win[m] = p;
      end
      #1;
      for (int p = 0; p < P; p++) begin
        logic er;
        er = req_valid[p] && win[tgt[p]] == p;
        chk("R2 R3 R4 req_ready", 64'(req_ready[p]), 64'(er));
        exp_rsp[p]  = er && !req_we[p];
        exp_data[p] = mem_word(tgt[p], wd[p]);
      end
      for (int m = 0; m < M; m++) begin
        chk(win[m] < 0 ? "R9 mem_valid" : "R5 mem_valid", 64'(mem_valid[m]), 64'(win[m] >= 0));
        if (win[m] >= 0) begin
          chk("R1 mem_addr", 64'(mem_addr[m*WAW +: WAW]), 64'(wd[win[m]]));
          chk("R5 mem_wdata", 64'(mem_wdata[m*DW +: DW]), 64'(req_wdata[win[m]*DW +: DW]));
          chk("R5 mem_we", 64'(mem_we[m]), 64'(req_we[win[m]]));
        end
      end
      @(negedge clk);
    end
    for (int p = 0; p < P; p++) begin
      chk(exp_rsp[p] ? "R6 rsp_valid" : "R7 rsp_valid", 64'(rsp_valid[p]), 64'(exp_rsp[p]));
      if (exp_rsp[p]) chk("R6 rsp_data", 64'(rsp_data[p*DW +: DW]), 64'(exp_data[p]));
    end
    req_valid = '0;
    @(negedge clk);
    chk("R7 no rsp when idle", 64'(rsp_valid), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule